// File: doc/BRIEF.md
# Write-only serial configuration slave

This block is a receive-only slave on a two-wire serial bus (I2C signalling). It loads a small bank of clock-enable and control bytes from the bus and holds them as parallel outputs for the neighbouring clock logic. The serial clock and data lines are sampled by a much faster system clock, at least eight times the bus clock rate. They pass through synchronizers before any decision is taken. The data line is open drain, so the block never drives it high. It only asserts a pull-low enable, and only during acknowledge slots.

A transfer opens with a start condition and the write address byte 0xD2. That byte carries the 7-bit device address 0x69 with the direction bit low. Two overhead bytes follow: a command byte and a count byte. Both are acknowledged and then discarded. Each further byte goes into the next control register, starting at register 0. There is no sub-address, and the bank cannot be read back. To change one register, the host must resend every byte that comes before it in the same transfer.

Top module: `cfg_wr_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins a transfer whose first byte is the address byte. A stop condition (SDA rising while SCL is high) ends the transfer and leaves `sda_pull_o` low.
- R2: Bytes are 8 bits, received most significant bit first on SCL rising edges. An accepted byte is acknowledged by raising `sda_pull_o` while SCL is low after the eighth bit and dropping it at the SCL fall that ends the ninth clock.
- R3: The address byte 0xD2 (address 0x69, direction bit 0) is acknowledged.
- R4: An address byte with direction bit 1 (such as 0xD3), or with any other address, gets no acknowledge. The block then acknowledges nothing and leaves the registers unchanged until the next start condition.
- R5: After an accepted address, the first two bytes are acknowledged and their values have no effect on any register.
- R6: The third and later bytes after the address are written to register 0, 1, 2 and so on, in order. Register i appears on `regs_o[8*i+7:8*i]`.
- R7: Bytes beyond the last register are acknowledged and leave every register unchanged.
- R8: After reset, every register reads 0xFF and `sda_pull_o` is low.
- R9: A repeated start in the middle of a transfer resets the byte position. The next byte is then treated as an address byte, and data after the overhead bytes again begins at register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired value) |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data line |
| regs_o | output | 8*NUM_REGS | Control register bank, register i in bits 8i+7..8i |

## Verification
A wrong byte position or bit count inside the block shows up first on the acknowledge pin. A slot is answered where none should be, or missed where one is due, within the same nine-clock byte that goes wrong. A wrong write target shows up on `regs_o`. It appears a few system clocks after the eighth bit of the byte, as a value landing in the wrong slot or an overhead byte leaking into a register. A missed start or stop shows up as a whole following transfer being acknowledged or ignored against the expected pattern. Random transfers of mixed length and address are therefore scored on every acknowledge bit and on every register after each stop.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int BYTE_W   = 8;
  localparam int BIT_CW   = 4;
  localparam int OVERHEAD = 3;  // address byte plus two ignored bytes

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BITS = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;

  // write address test: 7-bit address match and direction bit low
  function automatic logic addr_accept(input logic [BYTE_W-1:0] b,
                                       input logic [6:0] dev);
    return (b[BYTE_W-1:1] == dev) && !b[0];
  endfunction

  // byte position holds a data byte
  function automatic logic is_data_pos(input int unsigned pos);
    return pos >= OVERHEAD;
  endfunction

  // register slot targeted by a byte position
  function automatic int unsigned slot_of(input int unsigned pos);
    return pos - OVERHEAD;
  endfunction
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/cfgs_frame.sv
module cfgs_frame
  import cfgs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_pull,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int MAX_POS = NUM_REGS + OVERHEAD;

  phase_t            phase;
  logic [BIT_CW-1:0] bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  byte_pos;
  logic              pull_q;
  logic              wr_en_q;
  logic [IDX_W-1:0]  wr_idx_q;
  logic [BYTE_W-1:0] wr_data_q;

  // named internal events
  logic byte_full;
  logic ack_decide;
  logic addr_hit;
  logic take_byte;
  logic data_pos;

  assign byte_full  = (bitcnt == BIT_CW'(BYTE_W));
  assign ack_decide = (phase == PH_BITS) && byte_full && scl_fall && !start_det && !stop_det;
  assign addr_hit   = addr_accept(shreg, DEV_ADDR);
  assign take_byte  = (byte_pos != '0) || addr_hit;
  assign data_pos   = is_data_pos(int'(byte_pos));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_pos <= '0;
      pull_q   <= 1'b0;
    end else if (start_det) begin
      phase    <= PH_BITS;
      bitcnt   <= '0;
      byte_pos <= '0;
      pull_q   <= 1'b0;
    end else if (stop_det) begin
      phase  <= PH_IDLE;
      pull_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_BITS: begin
          if (scl_rise && !byte_full) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end
          if (ack_decide) begin
            if (take_byte) begin
              phase  <= PH_ACK;
              pull_q <= 1'b1;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            pull_q <= 1'b0;
            phase  <= PH_BITS;
            bitcnt <= '0;
            if (byte_pos != IDX_W'(MAX_POS)) byte_pos <= byte_pos + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= ack_decide && data_pos;
      if (ack_decide && data_pos) begin
        wr_idx_q  <= IDX_W'(slot_of(int'(byte_pos)));
        wr_data_q <= shreg;
      end
    end
  end

  assign sda_pull = pull_q;
  assign wr_en    = wr_en_q;
  assign wr_idx   = wr_idx_q;
  assign wr_data  = wr_data_q;

  AST_ACK_IN_LOW:    assert property (@(posedge clk) disable iff (!rst_n) $rose(pull_q) |-> !scl_s); // R2
  AST_BIT_LIMIT:     assert property (@(posedge clk) disable iff (!rst_n) bitcnt <= BIT_CW'(BYTE_W)); // R2
  AST_STOP_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !pull_q); // R1
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> (!pull_q && bitcnt == '0 && byte_pos == '0)); // R9
  AST_READ_NACK:     assert property (@(posedge clk) disable iff (!rst_n) (ack_decide && byte_pos == '0 && shreg[0]) |=> !pull_q); // R4
  AST_OVERHEAD_NOWR: assert property (@(posedge clk) disable iff (!rst_n) (ack_decide && (byte_pos == IDX_W'(1) || byte_pos == IDX_W'(2))) |=> !wr_en_q); // R5
endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank
  import cfgs_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W = 3,
  parameter logic [BYTE_W-1:0] RESET_VAL = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               regs_q[i] <= RESET_VAL;
      else if (wr_en && wr_idx == IDX_W'(i))    regs_q[i] <= wr_data;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = regs_q[i];
  end

  AST_WR_LANDS:   assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_idx < IDX_W'(NUM_REGS)) |=> regs_q[$past(wr_idx)] == $past(wr_data)); // R6
  AST_SURPLUS:    assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_idx >= IDX_W'(NUM_REGS)) |=> $stable(regs_flat)); // R7
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(regs_flat)); // R4
endmodule

// File: rtl/cfg_wr_slave.sv
module cfg_wr_slave
  import cfgs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  output logic [8*NUM_REGS-1:0]      regs_o
);
  localparam int IDX_W = $clog2(NUM_REGS + OVERHEAD + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  cfgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgs_frame #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfgs_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RESET_VAL(8'hFF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs_flat(regs_o)
  );

  AST_RESET_RELEASE: assert property (@(posedge clk) $rose(rst_n) |-> !sda_pull_o); // R8
endmodule

// File: tb/sim_cfg_wr_slave.sv
module sim_cfg_wr_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int QTR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  wire  sda_pull;
  wire  [8*NR-1:0] regs;
  wire  sda_line = m_sda & ~sda_pull;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_reg [NR];
  logic [7:0] tx [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_wr_slave #(.DEV_ADDR(7'h69), .NUM_REGS(NR), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .regs_o(regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitc(QTR);
    m_scl = 1'b1; waitc(2*QTR);
    m_sda = 1'b0; waitc(2*QTR);
    m_scl = 1'b0; waitc(QTR);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitc(QTR);
    m_scl = 1'b1; waitc(2*QTR);
    m_sda = 1'b1; waitc(2*QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; waitc(QTR);
      m_scl = 1'b1; waitc(2*QTR);
      m_scl = 1'b0; waitc(QTR);
    end
    m_sda = 1'b1; waitc(QTR);
    m_scl = 1'b1; waitc(QTR);
    ack = ~sda_line;
    waitc(QTR);
    m_scl = 1'b0; waitc(QTR);
  endtask

  function automatic string ack_tag(input int k);
    if (k == 0)       return "R2/R3/R4 address ack";
    else if (k < 3)   return "R5 overhead ack";
    else if (k - 3 < NR) return "R6 data ack";
    else              return "R7 surplus ack";
  endfunction

  function automatic bit addr_ok(input logic [7:0] b);
    return b == 8'hD2;
  endfunction

  task automatic check_regs(input string tag);
    for (int i = 0; i < NR; i++) chk(tag, regs[i*8 +: 8], exp_reg[i]);
  endtask

  task automatic txn(input int n, input bit do_stop);
    logic a;
    bit live;
    bus_start();
    live = 1'b0;
    for (int k = 0; k < n; k++) begin
      send_byte(tx[k], a);
      if (k == 0) live = addr_ok(tx[0]);
      chk(ack_tag(k), a, live);
      if (live && k >= 3 && k - 3 < NR) exp_reg[k-3] = tx[k];
    end
    if (do_stop) begin
      bus_stop();
      waitc(6);
      chk("R1 release after stop", sda_pull, 1'b0);
      check_regs("R4/R5/R6/R7 registers after stop");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) exp_reg[i] = 8'hFF;
    waitc(5);
    chk("R8 pull low in reset", sda_pull, 1'b0);
    rst_n = 1'b1;
    waitc(5);
    chk("R8 pull after reset", sda_pull, 1'b0);
    check_regs("R8 reset value");

    // full write with nonzero overhead bytes
    tx[0] = 8'hD2; tx[1] = 8'h5A; tx[2] = 8'hA5;
    tx[3] = 8'h01; tx[4] = 8'h80; tx[5] = 8'h3C; tx[6] = 8'hC3;
    txn(7, 1'b1);

    // read request and wrong address are ignored
    tx[0] = 8'hD3; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h77;
    txn(4, 1'b1);
    tx[0] = 8'hA4; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h66; tx[4] = 8'h55;
    txn(5, 1'b1);

    // surplus bytes beyond last register
    tx[0] = 8'hD2; tx[1] = 8'hFF; tx[2] = 8'hFF;
    for (int k = 3; k < 11; k++) tx[k] = 8'(k * 17);
    txn(11, 1'b1);

    // repeated start mid-transfer restarts at register 0
    tx[0] = 8'hD2; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h11;
    txn(4, 1'b0);
    tx[0] = 8'hD2; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h22; tx[4] = 8'h33;
    txn(5, 1'b1);
    chk("R9 reg0 after repeated start", regs[7:0], 8'h22);
    chk("R9 reg1 after repeated start", regs[15:8], 8'h33);

    // random transfers
    for (int t = 0; t < 30; t++) begin
      int len;
      len = 1 + int'($urandom % 9);
      tx[0] = ($urandom % 4 == 0) ? 8'($urandom) : 8'hD2;
      for (int k = 1; k < len; k++) tx[k] = 8'($urandom);
      txn(len, 1'b1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule